// File: doc/BRIEF.md
# Bus-Activity Watchdog Reset Supervisor

This block produces a stretched system reset from two sources: a digital supply-good flag and a watchdog timer that is fed by traffic on a two-wire serial bus. While supply-good is low the reset is held active at once, without waiting for a clock. Once supply-good returns, reset stays active until the flag has remained high for a full hold interval (250 ms by default). Any dropout inside that interval starts it again from zero.

The watchdog needs no dedicated kick pin. It watches the bus clock and data lines and treats a falling data edge while the bus clock is high (a START-style event) as a kick. When the watchdog is enabled and no kick arrives within the period chosen by a 2-bit select code, the block raises reset. That reset is stretched for the same hold interval as a power event, and the watchdog then counts again from zero. The output polarity is fixed by a parameter. Internally the reset is always carried active-high.

Top module: `bus_wdog_supervisor`

## Requirements
- R1: While `powerGood` is low, the reset is active immediately and asynchronously. This includes power-up, when the reset starts active.
- R2: After `powerGood` rises, the reset releases exactly HOLD_CYC+2 clock edges later, where HOLD_CYC = CLK_HZ*HOLD_MS/1000. Two of those edges are the synchroniser and HOLD_CYC is the hold count.
- R3: If `powerGood` drops at any point during the hold interval, the interval restarts from zero on its next rise, with the same timing as R2.
- R4: A kick is a high-to-low change of `sdaIn` while `sclIn` is high in both the previous and the current synchronised sample. The kick clears the watchdog count on the third clock edge after the SDA fall. An SDA fall while SCL is low, or any SDA rise, does not kick.
- R5: With the watchdog running, the reset asserts exactly L edges after the count was last cleared. Measured from an SDA kick this is L+3 edges, and measured from reset release it is L edges. L is the selected period in cycles.
- R6: `toSel` selects the period. Code 0 gives TO0_MS (default 1400 ms), code 1 gives TO1_MS (600 ms), code 2 gives TO2_MS (200 ms), and code 3 disables the watchdog.
- R7: With `wdEnable` low or `toSel`=3, the watchdog never raises reset. Its count is held at zero, so the full period L runs after it is re-enabled.
- R8: A watchdog reset stays active for exactly HOLD_CYC edges. After that the watchdog restarts from zero.
- R9: With RST_ACTIVE_LOW=1, `rstOut` is low while reset is active. With RST_ACTIVE_LOW=0, it is high while reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| powerGood | input | 1 | Supply-good flag, asynchronous, high when the supply is valid |
| sclIn | input | 1 | Serial bus clock line, sampled only |
| sdaIn | input | 1 | Serial bus data line, sampled only |
| wdEnable | input | 1 | Watchdog enable, high to run |
| toSel | input | 2 | Watchdog period code: 0/1/2 select a period, 3 disables |
| rstOut | output | 1 | System reset, polarity set by RST_ACTIVE_LOW |

## Verification
A corrupted hold count, watchdog count or supervisor state shows up only as a reset edge that arrives early, late or never. The bench therefore counts clock edges from each stimulus and compares the exact edge of release or assertion for every timeout code, so an off-by-one error is visible within one edge of the expected point. A spurious kick, such as one taken on an SDA rise or on a fall with SCL low, delays expiry by a whole period and is caught at the expected assertion edge. A missing asynchronous path is caught one time step after `powerGood` falls.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic holdRun;  // advance the hold counter
    logic holdClr;  // clear the hold counter
    logic wdRun;    // advance the watchdog counter
    logic wdClr;    // clear the watchdog counter
  } wdStrobe_t;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } supState_t;

  function automatic longint msToCycles(input longint hz, input longint ms);
    return (hz * ms) / 1000;
  endfunction

endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             arstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge arstN) begin
          if (!arstN) stage[i] <= RST_VAL;
          else        stage[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arstN) begin
          if (!arstN) stage[i] <= RST_VAL;
          else        stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];

endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int HOLD_CYC = 250,
  parameter int TO0_CYC = 1400,
  parameter int TO1_CYC = 600,
  parameter int TO2_CYC = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       powerGood,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] toSel,
  input  wdStrobe_t  strobe,
  output logic       pgoodSync,
  output logic       limitValid,
  output logic       kick,
  output logic       holdDone,
  output logic       wdExpire,
  output logic [$clog2(((TO0_CYC > TO1_CYC ? TO0_CYC : TO1_CYC) > TO2_CYC ?
                        (TO0_CYC > TO1_CYC ? TO0_CYC : TO1_CYC) : TO2_CYC) + 1)-1:0] wdCnt
);

  localparam int MAX01 = (TO0_CYC > TO1_CYC) ? TO0_CYC : TO1_CYC;
  localparam int MAX_TO = (MAX01 > TO2_CYC) ? MAX01 : TO2_CYC;
  localparam int WD_W = $clog2(MAX_TO + 1);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  // Supply-good synchroniser: asynchronous clear, synchronous release
  logic pgoodQ;
  wdog_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) pgoodSync_i (
    .clk(clk), .arstN(powerGood), .d(1'b1), .q(pgoodQ)
  );
  assign pgoodSync = pgoodQ;

  // Bus line synchronisers, idle-high
  logic [1:0] busQ;
  wdog_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) busSync_i (
    .clk(clk), .arstN(powerGood), .d({sclIn, sdaIn}), .q(busQ)
  );

  logic sclS, sdaS, sclPrev, sdaPrev;
  assign sclS = busQ[1];
  assign sdaS = busQ[0];

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign kick = sclS && sclPrev && sdaPrev && !sdaS;

  // Period selection
  logic [WD_W-1:0] wdLastVal;
  always_comb begin
    limitValid = 1'b1;
    case (toSel)
      2'd0:    wdLastVal = WD_W'(TO0_CYC - 1);
      2'd1:    wdLastVal = WD_W'(TO1_CYC - 1);
      2'd2:    wdLastVal = WD_W'(TO2_CYC - 1);
      default: begin
        wdLastVal  = '0;
        limitValid = 1'b0;
      end
    endcase
  end

  // Hold counter
  logic [HOLD_W-1:0] holdCnt;
  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood)          holdCnt <= '0;
    else if (strobe.holdClr) holdCnt <= '0;
    else if (strobe.holdRun) holdCnt <= holdCnt + 1'b1;
  end
  assign holdDone = strobe.holdRun && (holdCnt == HOLD_W'(HOLD_CYC - 1));

  // Watchdog counter; a kick wins over expiry in the same cycle
  logic [WD_W-1:0] wdCntQ;
  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood)                 wdCntQ <= '0;
    else if (strobe.wdClr || kick)  wdCntQ <= '0;
    else if (strobe.wdRun)          wdCntQ <= wdCntQ + 1'b1;
  end
  assign wdCnt = wdCntQ;
  assign wdExpire = strobe.wdRun && !kick && (wdCntQ == wdLastVal);

endmodule

// File: rtl/wdog_control.sv
module wdog_control
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       powerGood,
  input  logic       pgoodSync,
  input  logic       wdEnable,
  input  logic       limitValid,
  input  logic       holdDone,
  input  logic       wdExpire,
  output wdStrobe_t  strobe,
  output logic       rstActive
);

  supState_t state, stateNext;

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) state <= ST_HOLD;
    else            state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_HOLD: if (holdDone) stateNext = ST_RUN;
      ST_RUN:  if (wdExpire) stateNext = ST_HOLD;
      default: stateNext = ST_HOLD;
    endcase
  end

  always_comb begin
    strobe.holdRun = (state == ST_HOLD) && pgoodSync;
    strobe.holdClr = (state == ST_RUN);
    strobe.wdRun   = (state == ST_RUN) && wdEnable && limitValid;
    strobe.wdClr   = !strobe.wdRun;
  end

  assign rstActive = (state == ST_HOLD);

endmodule

// File: rtl/bus_wdog_supervisor.sv
module bus_wdog_supervisor
  import wdog_pkg::*;
#(
  parameter longint CLK_HZ = 50_000_000,
  parameter int HOLD_MS = 250,
  parameter int TO0_MS = 1400,
  parameter int TO1_MS = 600,
  parameter int TO2_MS = 200,
  parameter bit RST_ACTIVE_LOW = 1'b1
) (
  input  logic       clk,
  input  logic       powerGood,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       wdEnable,
  input  logic [1:0] toSel,
  output logic       rstOut
);

  localparam int HOLD_CYC = int'(msToCycles(CLK_HZ, longint'(HOLD_MS)));
  localparam int TO0_CYC = int'(msToCycles(CLK_HZ, longint'(TO0_MS)));
  localparam int TO1_CYC = int'(msToCycles(CLK_HZ, longint'(TO1_MS)));
  localparam int TO2_CYC = int'(msToCycles(CLK_HZ, longint'(TO2_MS)));
  localparam int MAX01 = (TO0_CYC > TO1_CYC) ? TO0_CYC : TO1_CYC;
  localparam int MAX_TO = (MAX01 > TO2_CYC) ? MAX01 : TO2_CYC;
  localparam int WD_W = $clog2(MAX_TO + 1);

  wdStrobe_t strobe;
  logic pgoodSync, limitValid, kick, holdDone, wdExpire, rstActive;
  logic [WD_W-1:0] wdCnt;

  wdog_datapath #(
    .HOLD_CYC(HOLD_CYC), .TO0_CYC(TO0_CYC), .TO1_CYC(TO1_CYC),
    .TO2_CYC(TO2_CYC), .SYNC_STAGES(2)
  ) datapath_i (
    .clk(clk), .powerGood(powerGood), .sclIn(sclIn), .sdaIn(sdaIn),
    .toSel(toSel), .strobe(strobe), .pgoodSync(pgoodSync),
    .limitValid(limitValid), .kick(kick), .holdDone(holdDone),
    .wdExpire(wdExpire), .wdCnt(wdCnt)
  );

  wdog_control control_i (
    .clk(clk), .powerGood(powerGood), .pgoodSync(pgoodSync),
    .wdEnable(wdEnable), .limitValid(limitValid), .holdDone(holdDone),
    .wdExpire(wdExpire), .strobe(strobe), .rstActive(rstActive)
  );

  generate
    if (RST_ACTIVE_LOW) begin : g_lowOut
      assign rstOut = !rstActive;
    end else begin : g_highOut
      assign rstOut = rstActive;
    end
  endgenerate

endmodule

// File: rtl/bus_wdog_supervisor_chk.sv
module bus_wdog_supervisor_chk #(
  parameter int WD_W = 8
) (
  input logic            clk,
  input logic            powerGood,
  input logic            wdEnable,
  input logic [1:0]      toSel,
  input logic            rstActive,
  input logic            kick,
  input logic            wdExpire,
  input logic [WD_W-1:0] wdCnt
);

  always @(posedge clk) begin
    if (!powerGood) begin
      AST_PGOOD_LOW_RESET: assert (rstActive);  // R1
    end
  end

  AST_RELEASE_AFTER_GOOD: assert property (@(posedge clk) disable iff (!powerGood)
    $fell(rstActive) |-> $past(powerGood, 2));  // R2

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!powerGood)
    (kick && !rstActive) |=> (wdCnt == '0));  // R4

  AST_EXPIRE_RESETS: assert property (@(posedge clk) disable iff (!powerGood)
    wdExpire |=> rstActive);  // R5

  AST_RESET_HAS_CAUSE: assert property (@(posedge clk) disable iff (!powerGood)
    ($rose(rstActive) && $past(powerGood)) |-> $past(wdExpire));  // R8

  AST_OFF_NO_EXPIRE: assert property (@(posedge clk) disable iff (!powerGood)
    (!wdEnable || toSel == 2'd3) |-> !wdExpire);  // R7

endmodule

bind bus_wdog_supervisor bus_wdog_supervisor_chk #(.WD_W(WD_W)) chk_i (
  .clk(clk), .powerGood(powerGood), .wdEnable(wdEnable), .toSel(toSel),
  .rstActive(rstActive), .kick(kick), .wdExpire(wdExpire), .wdCnt(wdCnt)
);

// File: tb/bus_wdog_supervisor_tb_top.sv
`timescale 1ns/1ps
module bus_wdog_supervisor_tb_top;

  localparam longint CLK_HZ = 1000;
  localparam int H = 250;
  localparam int T0 = 1400;
  localparam int T1 = 600;
  localparam int T2 = 200;

  logic clk = 1'b0;
  logic powerGood = 1'b0;
  logic sclIn = 1'b1;
  logic sdaIn = 1'b1;
  logic wdEnable = 1'b1;
  logic [1:0] toSel = 2'd2;
  logic rstN, rstHi;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bus_wdog_supervisor #(.CLK_HZ(CLK_HZ), .RST_ACTIVE_LOW(1'b1)) dut_i (
    .clk(clk), .powerGood(powerGood), .sclIn(sclIn), .sdaIn(sdaIn),
    .wdEnable(wdEnable), .toSel(toSel), .rstOut(rstN)
  );

  bus_wdog_supervisor #(.CLK_HZ(CLK_HZ), .RST_ACTIVE_LOW(1'b0)) dutHi_i (
    .clk(clk), .powerGood(powerGood), .sclIn(sclIn), .sdaIn(sdaIn),
    .wdEnable(wdEnable), .toSel(toSel), .rstOut(rstHi)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reset asserted, checked at the active-low output; R9 checks the pair
  task automatic chkRst(input bit expActive, input string req);
    chk((!rstN) == expActive, req, int'(!rstN), int'(expActive));
    chk(rstHi == !rstN, "R9", int'(rstHi), int'(!rstN));
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #5;
  endtask

  function automatic int periodOf(input int code);
    case (code)
      0: return T0;
      1: return T1;
      default: return T2;
    endcase
  endfunction

  task automatic waitRelease();
    for (int i = 0; i < 4000; i++) begin
      if (rstN === 1'b1) return;
      step(1);
    end
    chk(1'b0, "R2", 0, 1);
  endtask

  initial begin
    #3;
    chkRst(1'b1, "R1");  // power-up state
    step(3);
    chkRst(1'b1, "R1");

    // R2: release after synchroniser plus hold
    powerGood = 1'b1;
    step(H + 1);
    chkRst(1'b1, "R2");
    step(1);
    chkRst(1'b0, "R2");

    // R5/R6: expiry from release for each period code
    for (int code = 0; code < 3; code++) begin
      toSel = 2'(code);
      step(periodOf(code) - 1);
      chkRst(1'b0, "R6");
      step(1);
      chkRst(1'b1, "R6");
      // R8: stretched for exactly H edges
      step(H - 1);
      chkRst(1'b1, "R8");
      step(1);
      chkRst(1'b0, "R8");
    end

    // R8: watchdog restarts from zero after stretched reset (code 2 still set)
    step(T2 - 1);
    chkRst(1'b0, "R8");
    step(1);
    chkRst(1'b1, "R8");
    waitRelease();

    // R4/R5: single kick, expiry L+3 edges after SDA fall
    step(50);
    sdaIn = 1'b0;
    step(4);
    sdaIn = 1'b1;
    step(T2 + 2 - 4);
    chkRst(1'b0, "R5");
    step(1);
    chkRst(1'b1, "R5");
    waitRelease();

    // R4: periodic kicks keep reset away with the longest period
    toSel = 2'd0;
    step(1);
    for (int k = 0; k < 8; k++) begin
      sdaIn = 1'b0;
      step(4);
      sdaIn = 1'b1;
      step(496);
      chkRst(1'b0, "R4");
    end
    step(902);
    chkRst(1'b0, "R4");
    step(1);
    chkRst(1'b1, "R4");
    toSel = 2'd2;
    waitRelease();

    // R4: non-kick bus activity (fall with SCL low, rises) does not restart
    for (int k = 0; k < 20; k++) begin
      sclIn = 1'b0; step(2);
      sdaIn = 1'b0; step(2);
      sclIn = 1'b1; step(2);
      sdaIn = 1'b1; step(2);
    end
    step(T2 - 1 - 160);
    chkRst(1'b0, "R4");
    step(1);
    chkRst(1'b1, "R4");
    waitRelease();

    // R7: enable low holds off the watchdog; full period after re-enable
    wdEnable = 1'b0;
    step(3 * T2 + 50);
    chkRst(1'b0, "R7");
    wdEnable = 1'b1;
    step(T2 - 1);
    chkRst(1'b0, "R7");
    step(1);
    chkRst(1'b1, "R7");
    waitRelease();

    // R6/R7: code 3 disables
    toSel = 2'd3;
    step(T0 + 100);
    chkRst(1'b0, "R6");
    toSel = 2'd1;
    step(T1 - 1);
    chkRst(1'b0, "R7");
    step(1);
    chkRst(1'b1, "R7");

    // R3: dropout during the hold restarts it
    step(100);
    powerGood = 1'b0;
    #1;
    chkRst(1'b1, "R3");
    step(5);
    powerGood = 1'b1;
    step(H + 1);
    chkRst(1'b1, "R3");
    step(1);
    chkRst(1'b0, "R3");

    // R1: dropout while running asserts immediately
    toSel = 2'd3;
    step(20);
    powerGood = 1'b0;
    #1;
    chkRst(1'b1, "R1");
    step(10);
    chkRst(1'b1, "R1");
    powerGood = 1'b1;
    step(H + 2);
    chkRst(1'b0, "R2");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule